// File: doc/BRIEF.md
# Timer Interrupt Flag and Request Unit

This block holds the event flags and raises interrupt requests for a 16-bit timer with two compare channels and one capture channel. It contains a small up-counter that advances on each active timer tick. In free-running mode the counter wraps from its maximum value to zero. In the two clear-on-match modes it returns to zero on the tick after it equals a TOP value, taken either from compare channel A or from the capture register.

Four sources raise flags: counter overflow, compare A, compare B, and capture. In the mode that takes TOP from the capture register, the capture flag also marks the counter reaching TOP. A flag is raised only on an active tick. A flag is cleared by a per-source acknowledge pulse, or by a register write with a one in the flag's bit position. If a raise and a clear land in the same cycle, the raise wins. A request goes out for a source while its flag is set, its enable bit is set and the global enable is high. Forced-compare strobes are accepted at the ports but never raise a flag.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset the counter, every flag, the enable mask and every request are zero.
- R2: Flag byte and enable mask share one layout: bit 5 capture, bit 2 compare B, bit 1 compare A, bit 0 overflow. Bits 7, 6, 4 and 3 always read zero. A mask write (`reg_wr`=1, `reg_sel`=1) loads those four bits from `reg_wdata`.
- R3: A compare flag rises at the tick edge that moves the counter off a value equal to that channel's compare register. While the counter shows the matching value, the flag is still low.
- R4: `force_cmp_a` and `force_cmp_b` never set a flag.
- R5: A `cap_event` pulse on an active tick sets bit 5.
- R6: With `mode_sel`=2, the counter returns to zero on the tick after it equals `cap_top_val`, and that tick sets bit 5.
- R7: Each active tick adds one to the counter. With `mode_sel`=1 it returns to zero on the tick after it equals `cmp_a_val`. With `mode_sel`=0 or 3 it wraps from 0xFFFF to 0. Without a tick the counter holds its value.
- R8: The tick that moves the counter from 0xFFFF to 0 sets bit 0.
- R9: An `irq_ack` pulse clears its flag (index 0 overflow, 1 compare A, 2 compare B, 3 capture). A flag write (`reg_wr`=1, `reg_sel`=0) clears each flag whose bit is one in `reg_wdata`. Zero bits in the write leave flags unchanged.
- R10: When a set event and a clear hit the same flag in the same cycle, the flag ends up one.
- R11: `irq_req[i]` is high exactly while flag i, enable bit i and `gie` are all one (same index order as R9).
- R12: With `tick_en` low, no flag is set, even if a capture pulse or a counter match is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timer tick enable |
| mode_sel | input | 2 | 0 free-running, 1 TOP from compare A, 2 TOP from capture register, 3 free-running |
| cmp_a_val | input | 16 | Compare register A |
| cmp_b_val | input | 16 | Compare register B |
| cap_top_val | input | 16 | Capture register value, used as TOP in mode 2 |
| cap_event | input | 1 | Capture pin event pulse |
| force_cmp_a | input | 1 | Forced-compare strobe, channel A |
| force_cmp_b | input | 1 | Forced-compare strobe, channel B |
| irq_ack | input | 4 | Per-source interrupt acknowledge pulses |
| gie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 flag byte (write one to clear), 1 enable mask |
| reg_wdata | input | 8 | Register write data |
| flag_byte | output | 8 | Flag register byte |
| enable_mask | output | 8 | Enable mask byte |
| irq_req | output | 4 | Per-source interrupt requests |
| count_val | output | 16 | Counter value |

## Verification
The set path of a flag and its clear path can act in the same cycle. The set path is a counter match, capture pulse or overflow on a tick. The clear path is an acknowledge pulse or a write-one. The bench provokes this by loading a compare register with the value the counter shows at that moment, keeping the tick high, and sending an acknowledge or a write-one to the same flag in that cycle. A stretch of random stimulus then produces more such overlaps. The behavioural model applies "set beats clear" on every clock, and the DUT's flag byte must match the model's, with the colliding flag left at one.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int FLAG_W = 8;
  localparam int NSRC   = 4;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'b00,
    MODE_TOP_A   = 2'b01,
    MODE_TOP_CAP = 2'b10,
    MODE_FREE_X  = 2'b11
  } cnt_mode_e;

  // bit position of each source inside the flag/mask byte
  function automatic int src_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 5;
    endcase
  endfunction

  function automatic logic [FLAG_W-1:0] spread_src(input logic [NSRC-1:0] v);
    logic [FLAG_W-1:0] res;
    res = '0;
    for (int i = 0; i < NSRC; i++) res[src_pos(i)] = v[i];
    return res;
  endfunction

  function automatic logic [NSRC-1:0] gather_src(input logic [FLAG_W-1:0] b);
    logic [NSRC-1:0] res;
    for (int i = 0; i < NSRC; i++) res[i] = b[src_pos(i)];
    return res;
  endfunction
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_irq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] top_a,
  input  logic [CNT_W-1:0] top_cap,
  output logic [CNT_W-1:0] count,
  output logic             at_max
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, top_sel;
  logic             top_on, top_hit;

  always_comb begin
    top_on  = (mode == MODE_TOP_A) || (mode == MODE_TOP_CAP);
    top_sel = (mode == MODE_TOP_CAP) ? top_cap : top_a;
    top_hit = top_on && (cnt_q == top_sel);
    cnt_d   = cnt_q;
    if (tick_en) cnt_d = top_hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count  = cnt_q;
  assign at_max = (cnt_q == CNT_MAX);

  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
  assert_cnt_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt_q == CNT_MAX) |=> (cnt_q == '0));
  assert_cnt_top_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && mode == MODE_TOP_A && cnt_q == top_a) |=> (cnt_q == '0));
  assert_cnt_top_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && mode == MODE_TOP_CAP && cnt_q == top_cap) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_ev) flag_d = 1'b0;
    if (set_ev) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !flag_q);
endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate #(
  parameter int N = 4
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] mask,
  input  logic         gie,
  output logic [N-1:0] req
);
  always_comb begin
    req = flags & mask & {N{gie}};
  end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [1:0]        mode_sel,
  input  logic [CNT_W-1:0]  cmp_a_val,
  input  logic [CNT_W-1:0]  cmp_b_val,
  input  logic [CNT_W-1:0]  cap_top_val,
  input  logic              cap_event,
  input  logic              force_cmp_a,
  input  logic              force_cmp_b,
  input  logic [NSRC-1:0]   irq_ack,
  input  logic              gie,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [FLAG_W-1:0] reg_wdata,
  output logic [FLAG_W-1:0] flag_byte,
  output logic [FLAG_W-1:0] enable_mask,
  output logic [NSRC-1:0]   irq_req,
  output logic [CNT_W-1:0]  count_val
);
  localparam int SRC_OVF = 0;
  localparam int SRC_CA  = 1;
  localparam int SRC_CB  = 2;
  localparam int SRC_CAP = 3;

  logic             srst_n;
  cnt_mode_e        mode;
  logic [CNT_W-1:0] cnt;
  logic             cnt_at_max;
  logic             match_a, match_b, match_cap;
  logic [NSRC-1:0]  set_ev, clr_ev, w1c_bits, wr_bits;
  logic [NSRC-1:0]  flag_q;
  logic [NSRC-1:0]  mask_q, mask_d;

  tmr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign mode = cnt_mode_e'(mode_sel);

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (srst_n),
    .tick_en (tick_en),
    .mode    (mode),
    .top_a   (cmp_a_val),
    .top_cap (cap_top_val),
    .count   (cnt),
    .at_max  (cnt_at_max)
  );

  // set and clear events per source
  always_comb begin
    match_a   = (cnt == cmp_a_val);
    match_b   = (cnt == cmp_b_val);
    match_cap = (mode == MODE_TOP_CAP) && (cnt == cap_top_val);
    set_ev          = '0;
    set_ev[SRC_OVF] = tick_en && cnt_at_max;
    set_ev[SRC_CA]  = tick_en && match_a;
    set_ev[SRC_CB]  = tick_en && match_b;
    set_ev[SRC_CAP] = tick_en && (cap_event || match_cap);
    wr_bits  = gather_src(reg_wdata);
    w1c_bits = (reg_wr && !reg_sel) ? wr_bits : '0;
    clr_ev   = irq_ack | w1c_bits;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    tmr_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (srst_n),
      .set_ev (set_ev[i]),
      .clr_ev (clr_ev[i]),
      .flag   (flag_q[i])
    );

    assert_no_set_idle_R12: assert property (@(posedge clk) disable iff (!srst_n)
      (!tick_en && !flag_q[i]) |=> !flag_q[i]);
  end

  // enable mask register
  always_comb begin
    mask_d = mask_q;
    if (reg_wr && reg_sel) mask_d = wr_bits;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  tmr_irq_gate #(.N(NSRC)) u_gate (
    .flags (flag_q),
    .mask  (mask_q),
    .gie   (gie),
    .req   (irq_req)
  );

  assign flag_byte   = spread_src(flag_q);
  assign enable_mask = spread_src(mask_q);
  assign count_val   = cnt;

  assert_force_a_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (force_cmp_a && !(tick_en && cnt == cmp_a_val) && !flag_q[SRC_CA]) |=> !flag_q[SRC_CA]);
  assert_force_b_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (force_cmp_b && !(tick_en && cnt == cmp_b_val) && !flag_q[SRC_CB]) |=> !flag_q[SRC_CB]);
  assert_cmp_delay_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (tick_en && cnt == cmp_a_val) |=> flag_q[SRC_CA]);
endmodule

// File: tb/tmr_irq_unit_tb.sv
module tmr_irq_unit_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, tick_en, cap_ev, frc_a, frc_b, gie, reg_wr, reg_sel;
  logic [1:0]  mode_sel;
  logic [15:0] cmp_a, cmp_b, cap_top;
  logic [3:0]  ack;
  logic [7:0]  reg_wdata;
  logic [7:0]  flag_byte, enable_mask;
  logic [3:0]  irq_req;
  logic [15:0] count_val;

  tmr_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
    .cmp_a_val(cmp_a), .cmp_b_val(cmp_b), .cap_top_val(cap_top),
    .cap_event(cap_ev), .force_cmp_a(frc_a), .force_cmp_b(frc_b),
    .irq_ack(ack), .gie(gie), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .flag_byte(flag_byte), .enable_mask(enable_mask),
    .irq_req(irq_req), .count_val(count_val)
  );

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";
  int    m_cnt;
  bit [3:0] m_flg, m_msk;

  function automatic bit [7:0] spread(input bit [3:0] v);
    return {2'b00, v[3], 2'b00, v[2], v[1], v[0]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk({cur_req, " count"}, count_val, m_cnt);
    chk({cur_req, " flags"}, flag_byte, spread(m_flg));
    chk({cur_req, " mask"},  enable_mask, spread(m_msk));
    chk({cur_req, " irq"},   irq_req, m_flg & m_msk & {4{gie}});
  endtask

  // behavioural reference: next state from current inputs
  task automatic model_step();
    bit [3:0] s, c;
    bit hit;
    s = '0;
    if (tick_en) begin
      if (m_cnt == cmp_a) s[1] = 1'b1;
      if (m_cnt == cmp_b) s[2] = 1'b1;
      if (cap_ev) s[3] = 1'b1;
      if (mode_sel == 2'd2 && m_cnt == cap_top) s[3] = 1'b1;
      if (m_cnt == 65535) s[0] = 1'b1;
    end
    c = ack;
    if (reg_wr && !reg_sel) c = c | {reg_wdata[5], reg_wdata[2], reg_wdata[1], reg_wdata[0]};
    m_flg = s | (m_flg & ~c);
    if (reg_wr && reg_sel) m_msk = {reg_wdata[5], reg_wdata[2], reg_wdata[1], reg_wdata[0]};
    if (tick_en) begin
      hit = (mode_sel == 2'd1 && m_cnt == cmp_a) || (mode_sel == 2'd2 && m_cnt == cap_top);
      m_cnt = hit ? 0 : (m_cnt + 1) % 65536;
    end
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    compare_all();
    cap_ev = 0; frc_a = 0; frc_b = 0; ack = '0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; tick_en = 0; mode_sel = 0; cmp_a = 16'd5; cmp_b = 16'd9; cap_top = 16'hFFF0;
    cap_ev = 0; frc_a = 0; frc_b = 0; ack = '0; gie = 0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    m_cnt = 0; m_flg = '0; m_msk = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    compare_all();
    rst_n = 1;
    repeat (3) step();

    // R2 mask layout, reserved bits read zero
    cur_req = "R2";
    reg_wr = 1; reg_sel = 1; reg_wdata = 8'hFF; step();
    chk("R2 mask byte", enable_mask, 8'h27);

    // R3 compare flag one tick after match
    cur_req = "R3";
    tick_en = 1;
    repeat (5) step();
    chk("R3 counter at A", count_val, 5);
    chk("R3 A flag not yet", flag_byte[1], 0);
    step();
    chk("R3 A flag raised", flag_byte[1], 1);
    repeat (4) step();
    chk("R3 B flag raised", flag_byte[2], 1);

    // R11 request gating
    cur_req = "R11";
    gie = 1; step();
    chk("R11 requests", irq_req, 4'b0110);
    gie = 0; step();
    chk("R11 gie low", irq_req, 4'b0000);

    // R9 acknowledge and write-one-to-clear
    cur_req = "R9";
    ack = 4'b0010; step();
    chk("R9 ack clears A", flag_byte, 8'h04);
    reg_wr = 1; reg_sel = 0; reg_wdata = 8'h00; step();
    chk("R9 zero write keeps", flag_byte, 8'h04);
    reg_wr = 1; reg_sel = 0; reg_wdata = 8'h04; step();
    chk("R9 one write clears B", flag_byte, 8'h00);

    // R4 force strobes
    cur_req = "R4";
    for (int k = 0; k < 4; k++) begin frc_a = 1; frc_b = 1; step(); end
    chk("R4 no flag from force", flag_byte, 8'h00);

    // R12 no set without tick
    cur_req = "R12";
    tick_en = 0; cmp_a = 16'(m_cnt);
    for (int k = 0; k < 3; k++) begin cap_ev = 1; step(); end
    chk("R12 flags idle", flag_byte, 8'h00);
    chk("R12 count held", count_val, m_cnt);

    // R5 capture pulse
    cur_req = "R5";
    cmp_a = 16'd5; tick_en = 1; cap_ev = 1; step();
    chk("R5 capture flag", flag_byte, 8'h20);
    ack = 4'b1000; step();

    // R10 set beats clear
    cur_req = "R10";
    cmp_a = 16'(m_cnt); cmp_b = 16'(m_cnt); ack = 4'b0010;
    reg_wr = 1; reg_sel = 0; reg_wdata = 8'h04; step();
    chk("R10 set wins", flag_byte, 8'h06);
    reg_wr = 1; reg_sel = 0; reg_wdata = 8'h27; step();

    // R7 clear-on-match with compare A
    cur_req = "R7";
    mode_sel = 2'd1; cmp_a = 16'(m_cnt + 6); cmp_b = 16'd900;
    repeat (6) step();
    chk("R7 at TOP", count_val, cmp_a);
    step();
    chk("R7 back to zero", count_val, 0);
    reg_wr = 1; reg_sel = 0; reg_wdata = 8'h27; step();

    // R6 TOP from capture register
    cur_req = "R6";
    mode_sel = 2'd2; cap_top = 16'(m_cnt + 11); cmp_a = 16'd900;
    repeat (11) step();
    chk("R6 capture flag before TOP", flag_byte[5], 0);
    step();
    chk("R6 TOP sets capture", flag_byte[5], 1);
    chk("R6 counter zero", count_val, 0);

    // mixed random stimulus, set/clear collisions (R10)
    cur_req = "R10";
    for (int blk = 0; blk < 4; blk++) begin
      mode_sel = 2'(blk);
      cmp_a = 16'($urandom_range(10, 40));
      cmp_b = 16'($urandom_range(0, 40));
      cap_top = 16'($urandom_range(10, 40));
      for (int k = 0; k < 100; k++) begin
        tick_en = ($urandom_range(0, 3) != 0);
        cap_ev  = ($urandom_range(0, 7) == 0);
        frc_a   = $urandom_range(0, 1);
        frc_b   = $urandom_range(0, 1);
        ack     = 4'($urandom_range(0, 15)) & {3'b000, $urandom_range(0, 1) == 0};
        ack     = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'b0000;
        gie     = $urandom_range(0, 1);
        reg_wr  = ($urandom_range(0, 4) == 0);
        reg_sel = $urandom_range(0, 1);
        reg_wdata = 8'($urandom_range(0, 255));
        step();
      end
    end

    // R8 overflow in free-running mode
    cur_req = "R8";
    mode_sel = 2'd0; tick_en = 1; gie = 0;
    cmp_a = 16'd3; cmp_b = 16'd3; cap_top = 16'd3;
    reg_wr = 1; reg_sel = 0; reg_wdata = 8'h27; step();
    while (m_cnt != 65535) step();
    chk("R8 overflow not yet", flag_byte[0], 0);
    step();
    chk("R8 overflow flag", flag_byte[0], 1);
    chk("R8 wrapped", count_val, 0);

    finish_run();
  end
endmodule